// File: doc/BRIEF.md
# Hysteretic Auto White Balance Gain Loop

This block is a field-rate controller that steers a red-side and a blue-side white-balance gain until a measured chroma error pair, I and Q, sits inside a target white zone. Each field an upstream statistics engine presents a signed I/Q measurement and a one-cycle field-sync pulse. The loop can average the measurement over the last four or two fields, and it moves each gain by at most a small step on selected fields. Two zone sizes give hysteresis: a small zone that stops the loop and a larger one that wakes it again.

Gains are 9-bit codes. The auto-mode limits are 8-bit register fields that the block reads as 9-bit values with the lowest bit forced to one. Three fixed preset gain pairs, stored as 8-bit fields read as 9-bit values with the top bit forced to zero, can replace the automatic loop. A swap control exchanges which internal gain drives which output.

Top module: `wb_gain_loop`

## Requirements
- R1: On the first clock edge after reset release, with mode select 00, gainR and gainB load the midpoint floor(({maxR,1}+{minR,1})/2) and floor(({maxB,1}+{minB,1})/2), and converged is 0.
- R2: Mode select 01, 10 and 11 drive gainR/gainB from preset pair 1, 2 and 3 as {0,preset}, follow preset register changes one cycle later, ignore field pulses, and hold converged at 0.
- R3: A change of the mode select into 00 reloads the auto midpoints on the next edge, clears converged and restarts the field period count.
- R4: On a step field the gains change in the cycle after the field pulse: filtered I>0 lowers R by 1 and raises B by 1, I<0 does the opposite; Q>0 lowers B by 1, Q<0 raises it; zero contributes nothing, and the I and Q effects on B add.
- R5: Every stepped gain is clamped to [{min,1}, {max,1}] of its own side.
- R6: While not converged, a step field with |I| < innerI and |Q| < innerQ (4-bit fields, strict) sets converged and applies no step; converged rises only at a field pulse.
- R7: While converged, step fields apply nothing until |I| > outerI or |Q| > outerQ (7-bit fields, strict); that field clears converged and applies its step.
- R8: Only every N-th field pulse since the last load is a step field, N being the 8-bit period register; N=0 behaves as N=1.
- R9: Filter select 00 uses floor of the mean of the current and three previous field measurements, 01 the floor of the mean of the current and previous one, 10 and 11 the current value; history shifts at every field pulse and resets to zero.
- R10: swapRB=1 drives gainR from the blue-side gain and gainB from the red-side gain, combinationally.
- R11: Between field pulses, in auto mode, gains and converged stay unchanged whatever the measurement does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fieldSync | input | 1 | One-cycle pulse per field, measurement valid |
| measI | input | 8 | Signed I error measurement |
| measQ | input | 8 | Signed Q error measurement |
| modeSel | input | 2 | 00 auto, 01/10/11 preset pair 1/2/3 |
| filtSel | input | 2 | 00 four-field mean, 01 two-field mean, 1x none |
| swapRB | input | 1 | Exchange R and B gain outputs |
| innerI | input | 4 | Inner zone limit on |I| |
| innerQ | input | 4 | Inner zone limit on |Q| |
| outerI | input | 7 | Outer zone limit on |I| |
| outerQ | input | 7 | Outer zone limit on |Q| |
| stepPeriod | input | 8 | Fields per step decision |
| maxR | input | 8 | Red upper limit field |
| minR | input | 8 | Red lower limit field |
| maxB | input | 8 | Blue upper limit field |
| minB | input | 8 | Blue lower limit field |
| presetR1 | input | 8 | Preset pair 1 red |
| presetB1 | input | 8 | Preset pair 1 blue |
| presetR2 | input | 8 | Preset pair 2 red |
| presetB2 | input | 8 | Preset pair 2 blue |
| presetR3 | input | 8 | Preset pair 3 red |
| presetB3 | input | 8 | Preset pair 3 blue |
| gainR | output | 9 | Red gain code |
| gainB | output | 9 | Blue gain code |
| converged | output | 1 | Loop is inside the white zone |

## Verification
Checked on every cycle: gains never move without a load or step strobe, a step only happens on a field pulse and always leaves the loop unconverged, converged only rises at a field pulse and stays low in preset modes, and a stepped gain lands within its side's limits. Only the scenarios can show the step directions, the exact midpoint and preset codes, the strict inner and outer comparisons, the period spacing, the averaging arithmetic and the swap, because these need expected values worked out over several fields.

// File: rtl/wb_gain_pkg.sv
package wb_gain_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO = 2'b00,
    MODE_FIX1 = 2'b01,
    MODE_FIX2 = 2'b10,
    MODE_FIX3 = 2'b11
  } wbMode_e;

  typedef enum logic [1:0] {
    FILT_AVG4 = 2'b00,
    FILT_AVG2 = 2'b01,
    FILT_RAW  = 2'b10,
    FILT_RAW2 = 2'b11
  } wbFilt_e;

  // Control to datapath strobes
  typedef struct packed {
    logic              load;
    logic              step;
    logic signed [2:0] dR;
    logic signed [2:0] dB;
  } wbStrobe_t;

  localparam int SIDE_R = 0;
  localparam int SIDE_B = 1;
  localparam int NUM_SIDES = 2;
  localparam int NUM_CH = 2;

endpackage

// File: rtl/wb_meas_filter.sv
module wb_meas_filter
  import wb_gain_pkg::*;
#(
  parameter int MEAS_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     fieldSync,
  input  logic [1:0]               filtSel,
  input  logic signed [MEAS_W-1:0] measI,
  input  logic signed [MEAS_W-1:0] measQ,
  output logic signed [MEAS_W-1:0] filtI,
  output logic signed [MEAS_W-1:0] filtQ,
  output logic [MEAS_W:0]          magI,
  output logic [MEAS_W:0]          magQ
);

  localparam int DEPTH = 3;
  localparam int SUM_W = MEAS_W + 2;
  localparam int MAG_W = MEAS_W + 1;

  logic signed [MEAS_W-1:0] rawCh [NUM_CH];
  logic signed [MEAS_W-1:0] outCh [NUM_CH];
  logic [MAG_W-1:0]         magCh [NUM_CH];

  assign rawCh[0] = measI;
  assign rawCh[1] = measQ;

  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    logic signed [MEAS_W-1:0] hist [DEPTH];
    logic signed [SUM_W-1:0]  sumTwo;
    logic signed [SUM_W-1:0]  sumFour;
    logic signed [SUM_W-1:0]  picked;
    logic signed [MAG_W-1:0]  wide;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < DEPTH; k++) hist[k] <= '0;
      end else if (fieldSync) begin
        hist[0] <= rawCh[c];
        for (int k = 1; k < DEPTH; k++) hist[k] <= hist[k-1];
      end
    end

    always_comb begin
      sumTwo  = SUM_W'(rawCh[c]) + SUM_W'(hist[0]);
      sumFour = sumTwo + SUM_W'(hist[1]) + SUM_W'(hist[2]);
      case (filtSel)
        FILT_AVG4: picked = sumFour >>> 2;
        FILT_AVG2: picked = sumTwo >>> 1;
        default:   picked = SUM_W'(rawCh[c]);
      endcase
    end

    assign outCh[c] = MEAS_W'(picked);
    assign wide     = MAG_W'(outCh[c]);
    assign magCh[c] = wide[MAG_W-1] ? MAG_W'(-wide) : MAG_W'(wide);
  end

  assign filtI = outCh[0];
  assign filtQ = outCh[1];
  assign magI  = magCh[0];
  assign magQ  = magCh[1];

endmodule

// File: rtl/wb_gain_ctrl.sv
module wb_gain_ctrl
  import wb_gain_pkg::*;
#(
  parameter int MEAS_W   = 8,
  parameter int INNER_W  = 4,
  parameter int OUTER_W  = 7,
  parameter int PERIOD_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     fieldSync,
  input  logic [1:0]               modeSel,
  input  logic signed [MEAS_W-1:0] filtI,
  input  logic signed [MEAS_W-1:0] filtQ,
  input  logic [MEAS_W:0]          magI,
  input  logic [MEAS_W:0]          magQ,
  input  logic [INNER_W-1:0]       innerI,
  input  logic [INNER_W-1:0]       innerQ,
  input  logic [OUTER_W-1:0]       outerI,
  input  logic [OUTER_W-1:0]       outerQ,
  input  logic [PERIOD_W-1:0]      stepPeriod,
  output wbStrobe_t                strb,
  output logic                     converged
);

  localparam int MAG_W = MEAS_W + 1;
  localparam int CNT_W = PERIOD_W + 1;

  logic                primed;
  logic [1:0]          prevMode;
  logic [PERIOD_W-1:0] fieldCnt;
  logic                conv;

  logic modeChange, loadNow, periodHit;
  logic insideInner, beyondOuter, inZone, evalField, stepNow;
  logic signed [2:0] signI, signQ;

  assign modeChange = !primed || (modeSel != prevMode);
  assign loadNow    = modeChange || (modeSel != MODE_AUTO);
  assign periodHit  = (CNT_W'(fieldCnt) + CNT_W'(1)) >= CNT_W'(stepPeriod);

  assign insideInner = (magI < MAG_W'(innerI)) && (magQ < MAG_W'(innerQ));
  assign beyondOuter = (magI > MAG_W'(outerI)) || (magQ > MAG_W'(outerQ));
  assign inZone      = conv ? !beyondOuter : insideInner;

  assign evalField = fieldSync && !loadNow && periodHit;
  assign stepNow   = evalField && !inZone;

  always_comb begin
    if (filtI[MEAS_W-1])  signI = -3'sd1;
    else if (|filtI)      signI = 3'sd1;
    else                  signI = 3'sd0;
    if (filtQ[MEAS_W-1])  signQ = -3'sd1;
    else if (|filtQ)      signQ = 3'sd1;
    else                  signQ = 3'sd0;
  end

  always_comb begin
    strb.load = loadNow;
    strb.step = stepNow;
    strb.dR   = -signI;
    strb.dB   = signI - signQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed   <= 1'b0;
      prevMode <= MODE_AUTO;
      fieldCnt <= '0;
      conv     <= 1'b0;
    end else begin
      primed   <= 1'b1;
      prevMode <= modeSel;
      if (loadNow) begin
        fieldCnt <= '0;
        conv     <= 1'b0;
      end else if (fieldSync) begin
        if (periodHit) begin
          fieldCnt <= '0;
          conv     <= inZone;
        end else begin
          fieldCnt <= fieldCnt + 1'b1;
        end
      end
    end
  end

  assign converged = conv;

  // R8
  step_on_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> fieldSync);

  // R7
  step_clears_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> !converged);

  // R2
  fixed_no_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != MODE_AUTO) |=> !converged);

  // R11
  conv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fieldSync && !strb.load) |=> $stable(converged));

  // R6
  conv_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(converged) |-> $past(fieldSync));

endmodule

// File: rtl/wb_gain_dp.sv
module wb_gain_dp
  import wb_gain_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  wbStrobe_t          strb,
  input  logic [1:0]         modeSel,
  input  logic               swapRB,
  input  logic [FIELD_W-1:0] maxR,
  input  logic [FIELD_W-1:0] minR,
  input  logic [FIELD_W-1:0] maxB,
  input  logic [FIELD_W-1:0] minB,
  input  logic [FIELD_W-1:0] presetR1,
  input  logic [FIELD_W-1:0] presetB1,
  input  logic [FIELD_W-1:0] presetR2,
  input  logic [FIELD_W-1:0] presetB2,
  input  logic [FIELD_W-1:0] presetR3,
  input  logic [FIELD_W-1:0] presetB3,
  output logic [FIELD_W:0]   gainR,
  output logic [FIELD_W:0]   gainB
);

  localparam int GAIN_W = FIELD_W + 1;
  localparam int CALC_W = GAIN_W + 2;

  logic [GAIN_W-1:0]  hiLim  [NUM_SIDES];
  logic [GAIN_W-1:0]  loLim  [NUM_SIDES];
  logic [GAIN_W-1:0]  preVal [NUM_SIDES];
  logic [GAIN_W-1:0]  gain   [NUM_SIDES];
  logic signed [2:0]  delta  [NUM_SIDES];

  always_comb begin
    hiLim[SIDE_R] = {maxR, 1'b1};
    loLim[SIDE_R] = {minR, 1'b1};
    hiLim[SIDE_B] = {maxB, 1'b1};
    loLim[SIDE_B] = {minB, 1'b1};
    delta[SIDE_R] = strb.dR;
    delta[SIDE_B] = strb.dB;
    case (modeSel)
      MODE_FIX1: begin preVal[SIDE_R] = {1'b0, presetR1}; preVal[SIDE_B] = {1'b0, presetB1}; end
      MODE_FIX2: begin preVal[SIDE_R] = {1'b0, presetR2}; preVal[SIDE_B] = {1'b0, presetB2}; end
      MODE_FIX3: begin preVal[SIDE_R] = {1'b0, presetR3}; preVal[SIDE_B] = {1'b0, presetB3}; end
      default:   begin preVal[SIDE_R] = '0;               preVal[SIDE_B] = '0;               end
    endcase
  end

  for (genvar s = 0; s < NUM_SIDES; s++) begin : gSide
    logic [GAIN_W-1:0]        midVal;
    logic [GAIN_W-1:0]        seedVal;
    logic signed [CALC_W-1:0] trial;
    logic [GAIN_W-1:0]        clamped;

    assign midVal  = GAIN_W'(({1'b0, hiLim[s]} + {1'b0, loLim[s]}) >> 1);
    assign seedVal = (modeSel == MODE_AUTO) ? midVal : preVal[s];
    assign trial   = $signed({2'b00, gain[s]}) + CALC_W'(delta[s]);

    always_comb begin
      if (trial < $signed({2'b00, loLim[s]}))      clamped = loLim[s];
      else if (trial > $signed({2'b00, hiLim[s]})) clamped = hiLim[s];
      else                                         clamped = GAIN_W'(trial);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          gain[s] <= '0;
      else if (strb.load) gain[s] <= seedVal;
      else if (strb.step) gain[s] <= clamped;
    end

    // R11
    gain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.load && !strb.step) |=> $stable(gain[s]));

    // R5
    gain_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.step && (loLim[s] <= hiLim[s])) |=>
        ((gain[s] <= $past(hiLim[s])) && (gain[s] >= $past(loLim[s]))));
  end

  assign gainR = swapRB ? gain[SIDE_B] : gain[SIDE_R];
  assign gainB = swapRB ? gain[SIDE_R] : gain[SIDE_B];

endmodule

// File: rtl/wb_gain_loop.sv
module wb_gain_loop
  import wb_gain_pkg::*;
#(
  parameter int MEAS_W   = 8,
  parameter int FIELD_W  = 8,
  parameter int INNER_W  = 4,
  parameter int OUTER_W  = 7,
  parameter int PERIOD_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     fieldSync,
  input  logic signed [MEAS_W-1:0] measI,
  input  logic signed [MEAS_W-1:0] measQ,
  input  logic [1:0]               modeSel,
  input  logic [1:0]               filtSel,
  input  logic                     swapRB,
  input  logic [INNER_W-1:0]       innerI,
  input  logic [INNER_W-1:0]       innerQ,
  input  logic [OUTER_W-1:0]       outerI,
  input  logic [OUTER_W-1:0]       outerQ,
  input  logic [PERIOD_W-1:0]      stepPeriod,
  input  logic [FIELD_W-1:0]       maxR,
  input  logic [FIELD_W-1:0]       minR,
  input  logic [FIELD_W-1:0]       maxB,
  input  logic [FIELD_W-1:0]       minB,
  input  logic [FIELD_W-1:0]       presetR1,
  input  logic [FIELD_W-1:0]       presetB1,
  input  logic [FIELD_W-1:0]       presetR2,
  input  logic [FIELD_W-1:0]       presetB2,
  input  logic [FIELD_W-1:0]       presetR3,
  input  logic [FIELD_W-1:0]       presetB3,
  output logic [FIELD_W:0]         gainR,
  output logic [FIELD_W:0]         gainB,
  output logic                     converged
);

  logic signed [MEAS_W-1:0] filtI, filtQ;
  logic [MEAS_W:0]          magI, magQ;
  wbStrobe_t                strb;

  wb_meas_filter #(.MEAS_W(MEAS_W)) uFilter (
    .clk(clk), .rstN(rstN), .fieldSync(fieldSync), .filtSel(filtSel),
    .measI(measI), .measQ(measQ),
    .filtI(filtI), .filtQ(filtQ), .magI(magI), .magQ(magQ)
  );

  wb_gain_ctrl #(
    .MEAS_W(MEAS_W), .INNER_W(INNER_W), .OUTER_W(OUTER_W), .PERIOD_W(PERIOD_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .fieldSync(fieldSync), .modeSel(modeSel),
    .filtI(filtI), .filtQ(filtQ), .magI(magI), .magQ(magQ),
    .innerI(innerI), .innerQ(innerQ), .outerI(outerI), .outerQ(outerQ),
    .stepPeriod(stepPeriod), .strb(strb), .converged(converged)
  );

  wb_gain_dp #(.FIELD_W(FIELD_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .modeSel(modeSel), .swapRB(swapRB),
    .maxR(maxR), .minR(minR), .maxB(maxB), .minB(minB),
    .presetR1(presetR1), .presetB1(presetB1),
    .presetR2(presetR2), .presetB2(presetB2),
    .presetR3(presetR3), .presetB3(presetB3),
    .gainR(gainR), .gainB(gainB)
  );

endmodule

// File: tb/tb_wb_gain_loop.sv
`timescale 1ns/1ps
module tb_wb_gain_loop;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              fieldSync = 1'b0;
  logic signed [7:0] measI = '0;
  logic signed [7:0] measQ = '0;
  logic [1:0]        modeSel = 2'b00;
  logic [1:0]        filtSel = 2'b10;
  logic              swapRB = 1'b0;
  logic [3:0]        innerI = 4'd4, innerQ = 4'd4;
  logic [6:0]        outerI = 7'd20, outerQ = 7'd20;
  logic [7:0]        stepPeriod = 8'd1;
  logic [7:0]        maxR = 8'h90, minR = 8'h70, maxB = 8'h81, minB = 8'h7E;
  logic [7:0]        presetR1 = 8'hC3, presetB1 = 8'h40;
  logic [7:0]        presetR2 = 8'h11, presetB2 = 8'hEE;
  logic [7:0]        presetR3 = 8'h00, presetB3 = 8'hFF;
  logic [8:0]        gainR, gainB;
  logic              converged;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  wb_gain_loop dut (
    .clk(clk), .rstN(rstN), .fieldSync(fieldSync), .measI(measI), .measQ(measQ),
    .modeSel(modeSel), .filtSel(filtSel), .swapRB(swapRB),
    .innerI(innerI), .innerQ(innerQ), .outerI(outerI), .outerQ(outerQ),
    .stepPeriod(stepPeriod), .maxR(maxR), .minR(minR), .maxB(maxB), .minB(minB),
    .presetR1(presetR1), .presetB1(presetB1), .presetR2(presetR2),
    .presetB2(presetB2), .presetR3(presetR3), .presetB3(presetB3),
    .gainR(gainR), .gainB(gainB), .converged(converged)
  );

  typedef struct packed {
    logic signed [7:0] i;
    logic signed [7:0] q;
    logic [8:0]        r;
    logic [8:0]        b;
    logic              c;
  } vec_t;

  // Auto mode, period 1, no filtering, R limits 225..289, B limits 253..259
  localparam vec_t VEC [17] = '{
    '{ 8'sd10,   8'sd0,   9'd256, 9'd257, 1'b0},
    '{-8'sd10,   8'sd0,   9'd257, 9'd256, 1'b0},
    '{ 8'sd0,    8'sd10,  9'd257, 9'd255, 1'b0},
    '{ 8'sd0,   -8'sd10,  9'd257, 9'd256, 1'b0},
    '{ 8'sd30,  -8'sd30,  9'd256, 9'd258, 1'b0},
    '{ 8'sd30,  -8'sd30,  9'd255, 9'd259, 1'b0},
    '{ 8'sd30,  -8'sd30,  9'd254, 9'd259, 1'b0},
    '{ 8'sd2,   -8'sd3,   9'd254, 9'd259, 1'b1},
    '{ 8'sd15,   8'sd15,  9'd254, 9'd259, 1'b1},
    '{ 8'sd20,   8'sd0,   9'd254, 9'd259, 1'b1},
    '{ 8'sd21,   8'sd0,   9'd253, 9'd259, 1'b0},
    '{ 8'sd5,    8'sd0,   9'd252, 9'd259, 1'b0},
    '{ 8'sd4,    8'sd0,   9'd251, 9'd259, 1'b0},
    '{ 8'sd3,   -8'sd4,   9'd250, 9'd259, 1'b0},
    '{-8'sd3,    8'sd3,   9'd250, 9'd259, 1'b1},
    '{ 8'sd0,   -8'sd21,  9'd250, 9'd259, 1'b0},
    '{ 8'h80,    8'sd0,   9'd251, 9'd258, 1'b0}
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic field(input logic signed [7:0] i, input logic signed [7:0] q);
    @(negedge clk);
    measI = i;
    measQ = q;
    fieldSync = 1'b1;
    @(negedge clk);
    fieldSync = 1'b0;
  endtask

  task automatic reloadAuto();
    @(negedge clk);
    modeSel = 2'b01;
    @(negedge clk);
    modeSel = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: midpoints (289+225)/2=257, (259+253)/2=256
    chk("R1 reset gainR", gainR, 257);
    chk("R1 reset gainB", gainB, 256);
    chk("R1 reset converged", converged, 0);

    // R4 R5 R6 R7 table walk
    for (int n = 0; n < 17; n++) begin
      field(VEC[n].i, VEC[n].q);
      chk($sformatf("R4/R7 vec %0d gainR", n), gainR, VEC[n].r);
      chk($sformatf("R4/R5 vec %0d gainB", n), gainB, VEC[n].b);
      chk($sformatf("R6/R7 vec %0d converged", n), converged, VEC[n].c);
    end

    // R11: measurement moves without a field pulse
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      measI = 8'sd100 - 8'(n);
      measQ = -8'sd90;
    end
    @(negedge clk);
    chk("R11 hold gainR", gainR, 251);
    chk("R11 hold gainB", gainB, 258);
    chk("R11 hold converged", converged, 0);

    // R10 swap
    swapRB = 1'b1;
    #1;
    chk("R10 swap gainR", gainR, 258);
    chk("R10 swap gainB", gainB, 251);
    @(negedge clk);
    swapRB = 1'b0;

    // R2 fixed presets
    modeSel = 2'b01;
    @(negedge clk);
    chk("R2 pair1 gainR", gainR, 195);
    chk("R2 pair1 gainB", gainB, 64);
    chk("R2 pair1 converged", converged, 0);
    modeSel = 2'b10;
    @(negedge clk);
    chk("R2 pair2 gainR", gainR, 17);
    chk("R2 pair2 gainB", gainB, 238);
    modeSel = 2'b11;
    @(negedge clk);
    chk("R2 pair3 gainR", gainR, 0);
    chk("R2 pair3 gainB", gainB, 255);
    presetR3 = 8'h7F;
    @(negedge clk);
    chk("R2 live preset gainR", gainR, 127);
    field(8'sd50, 8'sd0);
    field(8'sd1, 8'sd1);
    chk("R2 field ignored gainR", gainR, 127);
    chk("R2 field ignored gainB", gainB, 255);
    chk("R2 field ignored converged", converged, 0);

    // R3 back to auto
    modeSel = 2'b00;
    @(negedge clk);
    chk("R3 reload gainR", gainR, 257);
    chk("R3 reload gainB", gainB, 256);
    chk("R3 reload converged", converged, 0);

    // R5 clamps
    for (int n = 0; n < 40; n++) field(8'sd50, 8'sd0);
    chk("R5 lower clamp gainR", gainR, 225);
    chk("R5 upper clamp gainB", gainB, 259);
    for (int n = 0; n < 70; n++) field(-8'sd50, 8'sd0);
    chk("R5 upper clamp gainR", gainR, 289);
    chk("R5 lower clamp gainB", gainB, 253);

    // R8 period 3 after a reload (R3 restarts the count)
    stepPeriod = 8'd3;
    reloadAuto();
    chk("R3 period reload gainR", gainR, 257);
    field(8'sd10, 8'sd0);
    chk("R8 field1 gainR", gainR, 257);
    field(8'sd10, 8'sd0);
    chk("R8 field2 gainR", gainR, 257);
    field(8'sd10, 8'sd0);
    chk("R8 field3 gainR", gainR, 256);
    stepPeriod = 8'd0;
    field(8'sd10, 8'sd0);
    chk("R8 period zero gainR", gainR, 255);
    stepPeriod = 8'd1;

    // R9 filters
    filtSel = 2'b00;
    repeat (4) field(8'sd0, 8'sd0);
    chk("R9 settle avg4 converged", converged, 1);
    filtSel = 2'b01;
    r0 = gainR;
    field(8'sd30, 8'sd0);
    chk("R9 avg2 of 30,0 stays converged", converged, 1);
    chk("R9 avg2 of 30,0 gainR", gainR, r0);
    field(8'sd30, 8'sd0);
    chk("R9 avg2 of 30,30 leaves", converged, 0);
    chk("R9 avg2 of 30,30 gainR", gainR, r0 - 1);
    filtSel = 2'b00;
    repeat (4) field(8'sd0, 8'sd0);
    chk("R9 resettle converged", converged, 1);
    r0 = gainR;
    field(8'sd60, 8'sd0);
    chk("R9 avg4 of 60,0,0,0 stays converged", converged, 1);
    chk("R9 avg4 of 60,0,0,0 gainR", gainR, r0);
    field(8'sd60, 8'sd0);
    chk("R9 avg4 of 60,60,0,0 leaves", converged, 0);
    chk("R9 avg4 of 60,60,0,0 gainR", gainR, r0 - 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule